// File: doc/BRIEF.md
# Guarded Regulator Voltage-Mode Switch

This block sits between the system bus and the control pins of a core-supply regulator. Software picks one of two voltage modes, a discharge setting and an operating style for the regulator. The control register is guarded by a 16-bit key register. A write to the control register is accepted only while the key register holds the unlock value. Writing anything else to the key register locks it again.

Whenever an accepted write flips the voltage-mode bit, the block drops the system clock enable and holds it low while the supply settles. The length of the hold depends on which oscillator drives the system when the write lands. It is a fixed count for the internal oscillator and a selectable count for the low-speed crystal. When the count runs out, the enable returns and a one-cycle completion pulse is raised. While the clock is held off, the block reports busy and ignores every register write.

Top module: `regmode_guard`

## Requirements
- R1: A write to the control register (address 1) changes nothing unless the key register is unlocked; it is unlocked by writing exactly 0x0096 to address 0.
- R2: Writing any value other than 0x0096 to address 0 locks the key again; a read of address 0 returns 1 in bit 0 when unlocked and 0 when locked, with all other bits 0.
- R3: Control register fields are bit 0 mode select (1 = normal mode, 0 = low-power mode), bit 1 discharge enable, and bits 3:2 regulator operation (0 = automatic, 2 = forced); accepted values drive `reg_mode`, `reg_discharge` and `reg_op` from the next cycle and read back at address 1.
- R4: An accepted write that changes the mode-select bit drives `clk_en` low from the cycle after the write.
- R5: With `src_xtal` = 0 (internal oscillator) at the write, `clk_en` stays low for exactly 4096 cycles.
- R6: With `src_xtal` = 1 (low-speed crystal) at the write, `clk_en` stays low for 16, 256, 1024 or 4096 cycles for `wait_cfg` = 0, 1, 2, 3.
- R7: `settle_done` is high for exactly one cycle, the first cycle in which `clk_en` is high again.
- R8: While the clock is held off, bit 15 of an address-1 read is 1, and writes to either register are ignored.
- R9: An accepted control write that keeps the mode-select bit the same updates the other fields without dropping `clk_en`.
- R10: After reset the block is in normal mode, automatic operation, discharge off, locked, `clk_en` high and `settle_done` low.
- R11: `src_xtal` and `wait_cfg` are sampled at the accepted write; changes during the hold do not alter its length.
- R12: Read data appears on `bus_rdata` the cycle after a read and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock, always running |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address: 0 key, 1 control |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| src_xtal | input | 1 | Active clock source: 0 internal oscillator, 1 low-speed crystal |
| wait_cfg | input | 2 | Crystal settling-count selector |
| clk_en | output | 1 | System clock enable |
| settle_done | output | 1 | One-cycle pulse when the clock enable returns |
| reg_mode | output | 1 | Regulator mode select |
| reg_discharge | output | 1 | Regulator discharge enable |
| reg_op | output | 2 | Regulator operation field |

## Verification
The embedded properties assume that `clk` keeps running through the hold, since the count runs on it, and that `src_xtal` and `wait_cfg` are stable in the write cycle. The stimulus drives every input on the falling edge, so all of them are settled at each rising edge. The stimulus also changes the source and wait inputs in the middle of a hold to show they are sampled only at the start. Bus strobes last one cycle, and no read and write are ever issued together.

// File: rtl/regmode_pkg.sv
package regmode_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_KEY  = 2'd0;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd1;
  localparam int unsigned CTRL_W = 4;

  // bit 0 mode, bit 1 discharge, bits 3:2 operation
  typedef struct packed {
    logic [1:0] op;
    logic       dis;
    logic       mode;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{op: 2'd0, dis: 1'b0, mode: 1'b1};
endpackage

// File: rtl/key_lock.sv
module key_lock #(
  parameter int unsigned       DW  = 16,
  parameter logic [DW-1:0]     KEY = 16'h0096
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_key,
  input  logic [DW-1:0] wdata,
  input  logic          busy,
  output logic          unlocked_o
);
  always_ff @(posedge clk) begin
    if (rst)                  unlocked_o <= 1'b0;
    else if (wr_key && !busy) unlocked_o <= (wdata == KEY);
  end

  // R8
  key_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(unlocked_o));
endmodule

// File: rtl/ctrl_regs.sv
module ctrl_regs
  import regmode_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              unlocked,
  input  logic              busy,
  output ctrl_t             ctrl_o,
  output logic              start_o
);
  logic accept;

  assign accept  = wr_ctrl && unlocked && !busy;
  assign start_o = accept && (wdata[0] != ctrl_o.mode);

  always_ff @(posedge clk) begin
    if (rst)         ctrl_o <= CTRL_RST;
    else if (accept) ctrl_o <= ctrl_t'(wdata);
  end

  // R1
  locked_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && !unlocked) |=> $stable(ctrl_o));

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && busy) |=> $stable(ctrl_o));

  // R9
  start_flip_chk: assert property (@(posedge clk) disable iff (rst)
    start_o |=> (ctrl_o.mode != $past(ctrl_o.mode)));
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int unsigned INT_WAIT = 4096,
  parameter int unsigned XT_W0    = 16,
  parameter int unsigned XT_W1    = 256,
  parameter int unsigned XT_W2    = 1024,
  parameter int unsigned XT_W3    = 4096
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       src_xtal,
  input  logic [1:0] wait_cfg,
  output logic       busy_o,
  output logic       clk_en_o,
  output logic       done_o
);
  localparam int unsigned MAX_A = (XT_W0 > XT_W1) ? XT_W0 : XT_W1;
  localparam int unsigned MAX_B = (XT_W2 > XT_W3) ? XT_W2 : XT_W3;
  localparam int unsigned MAX_X = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned MAX_W = (MAX_X > INT_WAIT) ? MAX_X : INT_WAIT;
  localparam int unsigned CNT_W = $clog2(MAX_W + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;

  always_comb begin
    if (!src_xtal) load_val = CNT_W'(INT_WAIT - 1);
    else begin
      case (wait_cfg)
        2'd0:    load_val = CNT_W'(XT_W0 - 1);
        2'd1:    load_val = CNT_W'(XT_W1 - 1);
        2'd2:    load_val = CNT_W'(XT_W2 - 1);
        default: load_val = CNT_W'(XT_W3 - 1);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      busy_o   <= 1'b0;
      clk_en_o <= 1'b1;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (busy_o) begin
        if (cnt_q == '0) begin
          busy_o   <= 1'b0;
          clk_en_o <= 1'b1;
          done_o   <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else if (start) begin
        cnt_q    <= load_val;
        busy_o   <= 1'b1;
        clk_en_o <= 1'b0;
      end
    end
  end

  // R4
  stop_on_start_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> !clk_en_o);

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && cnt_q != '0) |=> (busy_o && cnt_q == $past(cnt_q) - 1'b1));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R7
  done_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_en_o) |-> done_o);
endmodule

// File: rtl/regmode_guard.sv
module regmode_guard
  import regmode_pkg::*;
#(
  parameter logic [15:0] KEY      = 16'h0096,
  parameter int unsigned INT_WAIT = 4096,
  parameter int unsigned XT_W0    = 16,
  parameter int unsigned XT_W1    = 256,
  parameter int unsigned XT_W2    = 1024,
  parameter int unsigned XT_W3    = 4096
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  input  logic        src_xtal,
  input  logic [1:0]  wait_cfg,
  output logic        clk_en,
  output logic        settle_done,
  output logic        reg_mode,
  output logic        reg_discharge,
  output logic [1:0]  reg_op
);
  logic  wr_key, wr_ctrl, rd_any;
  logic  unlocked, busy, start;
  ctrl_t ctrl;

  assign wr_key  = bus_sel && bus_wr && (bus_addr == A_KEY);
  assign wr_ctrl = bus_sel && bus_wr && (bus_addr == A_CTRL);
  assign rd_any  = bus_sel && !bus_wr;

  key_lock #(.DW(DATA_W), .KEY(KEY)) i_key (
    .clk(clk), .rst(rst), .wr_key(wr_key), .wdata(bus_wdata),
    .busy(busy), .unlocked_o(unlocked)
  );

  ctrl_regs i_ctrl (
    .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl), .wdata(bus_wdata[CTRL_W-1:0]),
    .unlocked(unlocked), .busy(busy), .ctrl_o(ctrl), .start_o(start)
  );

  settle_timer #(
    .INT_WAIT(INT_WAIT), .XT_W0(XT_W0), .XT_W1(XT_W1),
    .XT_W2(XT_W2), .XT_W3(XT_W3)
  ) i_timer (
    .clk(clk), .rst(rst), .start(start), .src_xtal(src_xtal),
    .wait_cfg(wait_cfg), .busy_o(busy), .clk_en_o(clk_en),
    .done_o(settle_done)
  );

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (rd_any) begin
      case (bus_addr)
        A_KEY:   bus_rdata <= {15'd0, unlocked};
        A_CTRL:  bus_rdata <= {busy, 11'd0, ctrl};
        default: bus_rdata <= '0;
      endcase
    end
  end

  assign reg_mode      = ctrl.mode;
  assign reg_discharge = ctrl.dis;
  assign reg_op        = ctrl.op;

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_any |=> $stable(bus_rdata));
endmodule

// File: tb/test_regmode_guard.sv
module test_regmode_guard;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        src_xtal = 1'b0;
  logic [1:0]  wait_cfg = '0;
  logic        clk_en, settle_done, reg_mode, reg_discharge;
  logic [1:0]  reg_op;

  int checks = 0, fails = 0, cycles = 0;

  // behavioural reference state
  logic        m_unl, m_busy, m_clken, m_done, m_mode, m_dis;
  logic [1:0]  m_op;
  logic [15:0] m_rdata;
  int          m_rem;

  regmode_guard i_regmode_guard (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_xtal(src_xtal), .wait_cfg(wait_cfg), .clk_en(clk_en),
    .settle_done(settle_done), .reg_mode(reg_mode),
    .reg_discharge(reg_discharge), .reg_op(reg_op)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int interval(input logic xt, input logic [1:0] w);
    if (!xt) return 4096;
    case (w)
      2'd0: return 16;
      2'd1: return 256;
      2'd2: return 1024;
      default: return 4096;
    endcase
  endfunction

  // reference model, updated on every rising edge, compared shortly after
  always @(posedge clk) begin
    logic o_busy, o_unl, o_mode, o_dis;
    logic [1:0] o_op;
    cycles++;
    if (rst) begin
      m_unl = 0; m_busy = 0; m_clken = 1; m_done = 0;
      m_mode = 1; m_dis = 0; m_op = 0; m_rdata = 0; m_rem = 0;
    end else begin
      o_busy = m_busy; o_unl = m_unl; o_mode = m_mode; o_dis = m_dis; o_op = m_op;
      if (bus_sel && !bus_wr)
        m_rdata = (bus_addr == 2'd0) ? {15'd0, o_unl} :
                  (bus_addr == 2'd1) ? {o_busy, 11'd0, o_op, o_dis, o_mode} : 16'd0;
      m_done = 0;
      if (o_busy) begin
        if (m_rem == 0) begin m_busy = 0; m_clken = 1; m_done = 1; end
        else m_rem--;
      end
      if (bus_sel && bus_wr && !o_busy) begin
        if (bus_addr == 2'd0) m_unl = (bus_wdata == 16'h0096);
        else if (bus_addr == 2'd1 && o_unl) begin
          if (bus_wdata[0] != o_mode) begin
            m_busy = 1; m_clken = 0; m_rem = interval(src_xtal, wait_cfg) - 1;
          end
          m_mode = bus_wdata[0]; m_dis = bus_wdata[1]; m_op = bus_wdata[3:2];
        end
      end
    end
    #2;
    if (!rst) begin
      check("R4 clk_en", clk_en, m_clken);
      check("R7 settle_done", settle_done, m_done);
      check("R3 reg_mode", reg_mode, m_mode);
      check("R3 reg_discharge", reg_discharge, m_dis);
      check("R3 reg_op", reg_op, m_op);
      check("R12 bus_rdata", bus_rdata, m_rdata);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  // write a mode value and measure how long clk_en stays low
  task automatic switch_and_measure(input logic [15:0] d, input int exp, input string req);
    int n = 0;
    wr(2'd1, d);
    while (clk_en == 1'b0) begin n++; @(negedge clk); end
    check(req, n, exp);
    check("R7 done at reassert", settle_done, 1);
    @(negedge clk);
    check("R7 done one cycle", settle_done, 0);
  endtask

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    check("R10 clk_en", clk_en, 1);
    check("R10 done", settle_done, 0);
    check("R10 mode", reg_mode, 1);
    check("R10 discharge", reg_discharge, 0);
    check("R10 op", reg_op, 0);
    rd(2'd0, d); check("R10 locked", d, 0);

    // R1 locked write ignored
    wr(2'd1, 16'h000A);
    @(negedge clk);
    check("R1 locked mode", reg_mode, 1);
    check("R1 locked op", reg_op, 0);
    check("R1 no stop", clk_en, 1);

    // unlock
    wr(2'd0, 16'h0096);
    rd(2'd0, d); check("R2 unlocked read", d, 1);

    // R9 same mode, other fields change, no stop
    wr(2'd1, 16'h000B);
    check("R9 no stop", clk_en, 1);
    check("R9 op forced", reg_op, 2);
    check("R9 discharge", reg_discharge, 1);
    rd(2'd1, d); check("R3 readback", d, 16'h000B);

    // R6 crystal waits
    src_xtal = 1; wait_cfg = 2'd0;
    switch_and_measure(16'h000A, 16, "R6 wait0");
    wait_cfg = 2'd1;
    wr(2'd1, 16'h0001);
    // R8 busy readback and ignored writes
    rd(2'd1, d); check("R8 busy bit", d[15], 1);
    wr(2'd1, 16'h0000);
    wr(2'd0, 16'h1234);
    while (clk_en == 1'b0) @(negedge clk);
    check("R8 mode kept", reg_mode, 1);
    rd(2'd0, d); check("R8 key kept", d, 1);
    rd(2'd1, d); check("R8 busy clear", d[15], 0);

    wait_cfg = 2'd2;
    switch_and_measure(16'h0000, 1024, "R6 wait2");
    wait_cfg = 2'd3;
    switch_and_measure(16'h0001, 4096, "R6 wait3");

    // R5 internal oscillator, R11 inputs changed mid-hold
    src_xtal = 0;
    fork
      switch_and_measure(16'h0000, 4096, "R5 R11 internal");
      begin repeat (5) @(negedge clk); src_xtal = 1; wait_cfg = 2'd0; end
    join
    src_xtal = 0;

    // R2 relock, then R1 write ignored
    wr(2'd0, 16'h1234);
    rd(2'd0, d); check("R2 relocked read", d, 0);
    wr(2'd1, 16'h0001);
    @(negedge clk);
    check("R1 relocked no stop", clk_en, 1);
    check("R1 relocked mode", reg_mode, 0);

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=done", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule